// File: doc/BRIEF.md
# Pipelined Simple Dual-Port RAM

This block is a parameterised memory with one write port and one read port. A write stores a word at an address, and it can store only selected lanes of the word when lane masking is enabled. A read fetches the word at an address through a short pipeline. A single read-side clock enable advances that pipeline. A separate read-enable input only marks the result as valid and does not affect the access itself.

A user tag word enters with each read and leaves in the same cycle as the data it belongs to. This lets a caller match returned data to requests without keeping its own latency counter. Parameters set the word width, the depth, the lane masking and its lane width (8 or 9 bits), an optional output register, and whether the read port uses the write clock or its own clock. A reset clears only the valid flag. It never clears stored or returned data. The reset that acts is the one that belongs to the read port's clock.

Top module: `sdp_ram_pipe`

## Requirements
- R1: With lane masking on (`MASK_EN`=1, `LANE_W`=8), write-mask bit i governs data bits [8i+7:8i]. A lane whose mask bit is 0 keeps its stored value, and a write with an all-zero mask changes nothing.
- R2: With lane masking off, the write-mask input is ignored and `wr_en` alone writes the whole word.
- R3: With `SHARED_CLK`=1, the read port runs on `wr_clk`. With `SHARED_CLK`=0, it runs only on `rd_clk`, and no read completes while `rd_clk` is stopped.
- R4: While `rd_pipe_en` is low, `rd_data`, `rd_valid` and `rd_tag_out` hold their values, even when the address, `rd_en` or the memory contents change.
- R5: `rd_en` does not affect the access. A read with `rd_en` low still returns the stored word on `rd_data`, with `rd_valid` low.
- R6: The tag captured with a read appears on `rd_tag_out` in the same cycle as that read's data. A tag width of 0 is accepted and uses a 1-bit tag port whose value carries no meaning.
- R7: Read latency is 2 cycles with `rd_pipe_en` high when `OUT_REG`=1, and 1 such cycle when `OUT_REG`=0.
- R8: The valid flag is cleared by `wr_rst` when `SHARED_CLK`=1 and by `rd_rst` when `SHARED_CLK`=0. The other reset input has no effect.
- R9: In shared-clock mode, a read and a write to the same address on the same edge return the previous contents.
- R10: Reset clears `rd_valid` but leaves `rd_data` and the memory contents unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Write clock. Also the read clock when `SHARED_CLK`=1 |
| wr_rst | input | 1 | Synchronous active-high valid reset, used when `SHARED_CLK`=1 |
| wr_en | input | 1 | Write enable |
| wr_lane_en | input | LANES | Per-lane write mask. Its width is 1 when masking is off |
| wr_addr | input | ADDR_W | Write address |
| wr_data | input | WORD_W | Write data |
| rd_clk | input | 1 | Read clock, used when `SHARED_CLK`=0 |
| rd_rst | input | 1 | Synchronous active-high valid reset, used when `SHARED_CLK`=0 |
| rd_en | input | 1 | Marks the read as valid |
| rd_pipe_en | input | 1 | Clock enable for the whole read pipeline |
| rd_tag_in | input | TAG_WI | Tag captured with the read |
| rd_addr | input | ADDR_W | Read address |
| rd_data | output | WORD_W | Read data |
| rd_tag_out | output | TAG_WI | Tag aligned with `rd_data` |
| rd_valid | output | 1 | Valid flag for `rd_data` |

## Verification
Assertions check the following on every read-clock edge:
- The read outputs freeze whenever the pipeline enable is low.
- `rd_valid` is low on the cycle after a reset.
- The valid flag and the tag at the output equal the read enable and tag sampled one or two enabled cycles earlier.

The directed scenarios cover the behaviours that depend on stored contents:
- lane-selective writes and the ignored mask when masking is off;
- read-before-write on a shared address;
- data that survives a reset;
- a read port that stays silent while its own clock is stopped.

// File: rtl/sdp_ram_pkg.sv
package sdp_ram_pkg;

  function automatic int unsigned addr_bits(input int unsigned depth);
    return (depth < 2) ? 1 : $clog2(depth);
  endfunction

  function automatic int unsigned at_least_one(input int unsigned v);
    return (v == 0) ? 1 : v;
  endfunction

endpackage

// File: rtl/sdp_ram_lane_mask.sv
module sdp_ram_lane_mask #(
  parameter int unsigned LANES   = 4,
  parameter bit          MASK_EN = 1'b1
) (
  input  logic             wr_en,
  input  logic [LANES-1:0] lane_en,
  output logic [LANES-1:0] strobe
);

  // With masking off the mask input is ignored and the enable covers the word.
  assign strobe = MASK_EN ? (lane_en & {LANES{wr_en}}) : {LANES{wr_en}};

endmodule

// File: rtl/sdp_ram_array.sv
module sdp_ram_array #(
  parameter int unsigned WORD_W  = 32,
  parameter int unsigned DEPTH   = 64,
  parameter int unsigned LANES   = 4,
  parameter int unsigned LANE_SZ = 8,
  parameter int unsigned ADDR_W  = 6
) (
  input  logic              wclk,
  input  logic [LANES-1:0]  strobe,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [WORD_W-1:0] wdata,
  input  logic              rclk,
  input  logic              rce,
  input  logic [ADDR_W-1:0] raddr,
  output logic [WORD_W-1:0] rdata
);

  logic [WORD_W-1:0] mem [DEPTH];

  // Byte-enable style write, one lane per strobe bit.
  always_ff @(posedge wclk) begin
    for (int i = 0; i < LANES; i++) begin
      if (strobe[i]) begin
        mem[waddr][i*LANE_SZ +: LANE_SZ] <= wdata[i*LANE_SZ +: LANE_SZ];
      end
    end
  end

  // Synchronous read. Non-blocking update gives read-first on a shared clock.
  always_ff @(posedge rclk) begin
    if (rce) begin
      rdata <= mem[raddr];
    end
  end

endmodule

// File: rtl/sdp_ram_rdpipe.sv
module sdp_ram_rdpipe #(
  parameter int unsigned WORD_W  = 32,
  parameter int unsigned TAG_WI  = 4,
  parameter bit          OUT_REG = 1'b1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ce,
  input  logic              rd_en,
  input  logic [TAG_WI-1:0] tag_in,
  input  logic [WORD_W-1:0] arr_data,
  output logic [WORD_W-1:0] data_out,
  output logic [TAG_WI-1:0] tag_out,
  output logic              valid_out
);

  logic              v1;
  logic [TAG_WI-1:0] t1;

  // First stage runs alongside the array read register.
  always_ff @(posedge clk) begin
    if (ce) begin
      t1 <= tag_in;
    end
    if (rst) begin
      v1 <= 1'b0;
    end else if (ce) begin
      v1 <= rd_en;
    end
  end

  generate
    if (OUT_REG) begin : g_out_reg
      logic [WORD_W-1:0] d2;
      logic [TAG_WI-1:0] t2;
      logic              v2;
      always_ff @(posedge clk) begin
        if (ce) begin
          d2 <= arr_data;
          t2 <= t1;
        end
        if (rst) begin
          v2 <= 1'b0;
        end else if (ce) begin
          v2 <= v1;
        end
      end
      assign data_out  = d2;
      assign tag_out   = t2;
      assign valid_out = v2;
    end else begin : g_direct
      assign data_out  = arr_data;
      assign tag_out   = t1;
      assign valid_out = v1;
    end
  endgenerate

  // R4: a stalled pipeline freezes every output.
  assert_hold_when_stalled_R4: assert property (@(posedge clk) disable iff (rst)
    !ce |=> ($stable(data_out) && $stable(tag_out) && $stable(valid_out)))
    else $error("read pipeline moved while stalled");

  // R8: valid is low on the cycle after a reset.
  logic rst_q;
  always_ff @(posedge clk) begin
    rst_q <= rst;
    if (rst_q) begin
      assert_valid_cleared_R8: assert (!valid_out)
        else $error("valid not cleared by reset");
    end
  end

endmodule

// File: rtl/sdp_ram_pipe.sv
module sdp_ram_pipe
  import sdp_ram_pkg::*;
#(
  parameter int unsigned WORD_W     = 32,
  parameter int unsigned DEPTH      = 64,
  parameter bit          MASK_EN    = 1'b1,
  parameter int unsigned LANE_W     = 8,
  parameter bit          SHARED_CLK = 1'b1,
  parameter bit          OUT_REG    = 1'b1,
  parameter int unsigned TAG_W      = 4,
  localparam int unsigned ADDR_W    = addr_bits(DEPTH),
  localparam int unsigned LANES     = MASK_EN ? (WORD_W / LANE_W) : 1,
  localparam int unsigned TAG_WI    = at_least_one(TAG_W)
) (
  input  logic              wr_clk,
  input  logic              wr_rst,
  input  logic              wr_en,
  input  logic [LANES-1:0]  wr_lane_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [WORD_W-1:0] wr_data,
  input  logic              rd_clk,
  input  logic              rd_rst,
  input  logic              rd_en,
  input  logic              rd_pipe_en,
  input  logic [TAG_WI-1:0] rd_tag_in,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [WORD_W-1:0] rd_data,
  output logic [TAG_WI-1:0] rd_tag_out,
  output logic              rd_valid
);

  localparam int unsigned LANE_SZ = MASK_EN ? LANE_W : WORD_W;

  generate
    if (MASK_EN && (((WORD_W % LANE_W) != 0) || ((LANE_W != 8) && (LANE_W != 9)))) begin : g_bad_cfg
      $error("lane width must be 8 or 9 and divide the word width");
    end
  endgenerate

  // Read-domain clock and reset selection (R3, R8).
  logic rclk_i;
  logic rrst_i;
  assign rclk_i = SHARED_CLK ? wr_clk : rd_clk;
  assign rrst_i = SHARED_CLK ? wr_rst : rd_rst;

  logic [LANES-1:0]  strobe;
  logic [WORD_W-1:0] arr_q;

  sdp_ram_lane_mask #(
    .LANES   (LANES),
    .MASK_EN (MASK_EN)
  ) u_mask (
    .wr_en   (wr_en),
    .lane_en (wr_lane_en),
    .strobe  (strobe)
  );

  sdp_ram_array #(
    .WORD_W  (WORD_W),
    .DEPTH   (DEPTH),
    .LANES   (LANES),
    .LANE_SZ (LANE_SZ),
    .ADDR_W  (ADDR_W)
  ) u_array (
    .wclk    (wr_clk),
    .strobe  (strobe),
    .waddr   (wr_addr),
    .wdata   (wr_data),
    .rclk    (rclk_i),
    .rce     (rd_pipe_en),
    .raddr   (rd_addr),
    .rdata   (arr_q)
  );

  sdp_ram_rdpipe #(
    .WORD_W  (WORD_W),
    .TAG_WI  (TAG_WI),
    .OUT_REG (OUT_REG)
  ) u_rdpipe (
    .clk       (rclk_i),
    .rst       (rrst_i),
    .ce        (rd_pipe_en),
    .rd_en     (rd_en),
    .tag_in    (rd_tag_in),
    .arr_data  (arr_q),
    .data_out  (rd_data),
    .tag_out   (rd_tag_out),
    .valid_out (rd_valid)
  );

  generate
    if (OUT_REG) begin : g_chk_two
      // R5/R7: valid equals rd_en from two enabled cycles back.
      assert_valid_follows_rden_R5: assert property (@(posedge rclk_i) disable iff (rrst_i)
        (rd_pipe_en && $past(rd_pipe_en) && !$past(rrst_i)) |=> (rd_valid == $past(rd_en, 2)))
        else $error("valid does not follow read enable");
      // R6: tag leaves with its data.
      assert_tag_aligned_R6: assert property (@(posedge rclk_i) disable iff (rrst_i)
        (rd_pipe_en && $past(rd_pipe_en)) |=> (rd_tag_out == $past(rd_tag_in, 2)))
        else $error("tag misaligned");
    end else begin : g_chk_one
      assert_valid_follows_rden_R5: assert property (@(posedge rclk_i) disable iff (rrst_i)
        rd_pipe_en |=> (rd_valid == $past(rd_en)))
        else $error("valid does not follow read enable");
      assert_tag_aligned_R6: assert property (@(posedge rclk_i) disable iff (rrst_i)
        rd_pipe_en |=> (rd_tag_out == $past(rd_tag_in)))
        else $error("tag misaligned");
    end
  endgenerate

endmodule

// File: tb/sdp_ram_pipe_tb_top.sv
module sdp_ram_pipe_tb_top;

  localparam int CLK_P  = 10;
  localparam int RCLK_P = 14;

  logic clk = 1'b0;
  logic rclk = 1'b0;
  logic rclk_run = 1'b1;
  always #(CLK_P/2) clk = ~clk;
  always begin
    #(RCLK_P/2);
    if (rclk_run) rclk = ~rclk;
  end

  int n_chk = 0;
  int n_fail = 0;

  // Shared write signals
  logic        wrst = 1'b1;
  logic        wr_en = 1'b0;
  logic [3:0]  wr_lane = 4'h0;
  logic [5:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic        junk_rst = 1'b1;

  // DUT 1: shared clock, output register, lane mask
  logic        pe = 1'b0, ren = 1'b0;
  logic [5:0]  raddr = '0;
  logic [3:0]  tag_i = '0;
  logic [31:0] rdata;
  logic [3:0]  tag_o;
  logic        rvalid;

  sdp_ram_pipe dut_i (
    .wr_clk(clk), .wr_rst(wrst), .wr_en(wr_en), .wr_lane_en(wr_lane),
    .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_clk(rclk), .rd_rst(junk_rst), .rd_en(ren), .rd_pipe_en(pe),
    .rd_tag_in(tag_i), .rd_addr(raddr),
    .rd_data(rdata), .rd_tag_out(tag_o), .rd_valid(rvalid)
  );

  // DUT 2: split clock, no output register, no mask, zero tag width
  logic        rrst = 1'b1;
  logic        pe2 = 1'b0, ren2 = 1'b0;
  logic [5:0]  raddr2 = '0;
  logic [0:0]  lane2 = 1'b0;
  logic [0:0]  tag2_o;
  logic [31:0] rdata2;
  logic        rvalid2;

  sdp_ram_pipe #(.MASK_EN(1'b0), .SHARED_CLK(1'b0), .OUT_REG(1'b0), .TAG_W(0)) dut2_i (
    .wr_clk(clk), .wr_rst(junk_rst), .wr_en(wr_en), .wr_lane_en(lane2),
    .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_clk(rclk), .rd_rst(rrst), .rd_en(ren2), .rd_pipe_en(pe2),
    .rd_tag_in(1'b0), .rd_addr(raddr2),
    .rd_data(rdata2), .rd_tag_out(tag2_o), .rd_valid(rvalid2)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic wr_word(input logic [5:0] a, input logic [31:0] d, input logic [3:0] m);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d; wr_lane = m;
    @(negedge clk);
    wr_en = 1'b0; wr_lane = 4'h0;
  endtask

  // Two enabled edges, then stall so the result holds.
  task automatic read_a(input logic [5:0] a, input logic [3:0] t, input logic re);
    @(negedge clk);
    pe = 1'b1; ren = re; raddr = a; tag_i = t;
    @(negedge clk);
    ren = 1'b0;
    @(negedge clk);
    pe = 1'b0;
  endtask

  task automatic t_reset();
    chk(rvalid === 1'b0, "R8", "shared valid after reset", {31'd0, rvalid}, 32'd0);
    chk(rvalid2 === 1'b0, "R8", "split valid after reset", {31'd0, rvalid2}, 32'd0);
  endtask

  task automatic t_mask();
    wr_word(6'd3, 32'h11223344, 4'hF);
    wr_word(6'd3, 32'hAABBCCDD, 4'b0101);
    read_a(6'd3, 4'h1, 1'b1);
    chk(rdata === 32'h11BB33DD, "R1", "lane masked write", rdata, 32'h11BB33DD);
    chk(rvalid === 1'b1, "R1", "valid on masked read", {31'd0, rvalid}, 32'd1);
    wr_word(6'd3, 32'h00000000, 4'h0);
    read_a(6'd3, 4'h1, 1'b1);
    chk(rdata === 32'h11BB33DD, "R1", "zero mask leaves word", rdata, 32'h11BB33DD);
  endtask

  task automatic t_rden();
    read_a(6'd3, 4'h2, 1'b0);
    chk(rdata === 32'h11BB33DD, "R5", "data without rd_en", rdata, 32'h11BB33DD);
    chk(rvalid === 1'b0, "R5", "valid low without rd_en", {31'd0, rvalid}, 32'd0);
  endtask

  task automatic t_latency();
    @(negedge clk);
    pe = 1'b1; ren = 1'b1; raddr = 6'd3; tag_i = 4'h5;
    @(negedge clk);
    ren = 1'b0; tag_i = 4'h0;
    chk(rvalid === 1'b0, "R7", "not valid after one edge", {31'd0, rvalid}, 32'd0);
    @(negedge clk);
    pe = 1'b0;
    chk(rvalid === 1'b1, "R7", "valid after two edges", {31'd0, rvalid}, 32'd1);
    chk(tag_o === 4'h5, "R6", "tag aligned with data", {28'd0, tag_o}, 32'd5);
    chk(rdata === 32'h11BB33DD, "R7", "data after two edges", rdata, 32'h11BB33DD);
  endtask

  task automatic t_hold();
    wr_word(6'd7, 32'hCAFE0007, 4'hF);
    @(negedge clk);
    pe = 1'b1; ren = 1'b1; raddr = 6'd7; tag_i = 4'h9;
    @(negedge clk);
    pe = 1'b0; ren = 1'b1; raddr = 6'd3; tag_i = 4'h2;
    wr_word(6'd7, 32'hDEAD0007, 4'hF);
    chk(rvalid === 1'b0, "R4", "stalled output valid", {31'd0, rvalid}, 32'd0);
    @(negedge clk);
    pe = 1'b1; ren = 1'b0;
    @(negedge clk);
    pe = 1'b0; ren = 1'b1;
    chk(rdata === 32'hCAFE0007, "R4", "stalled read data", rdata, 32'hCAFE0007);
    chk(rvalid === 1'b1, "R4", "stalled read valid", {31'd0, rvalid}, 32'd1);
    chk(tag_o === 4'h9, "R6", "stalled read tag", {28'd0, tag_o}, 32'd9);
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      raddr = 6'(i); ren = ~ren; tag_i = 4'(i);
    end
    @(negedge clk);
    ren = 1'b0;
    chk(rdata === 32'hCAFE0007 && rvalid === 1'b1 && tag_o === 4'h9, "R4",
        "outputs held while stalled", rdata, 32'hCAFE0007);
  endtask

  task automatic t_rfirst();
    wr_word(6'd10, 32'h01010101, 4'hF);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = 6'd10; wr_data = 32'h02020202; wr_lane = 4'hF;
    pe = 1'b1; ren = 1'b1; raddr = 6'd10; tag_i = 4'h1;
    @(negedge clk);
    wr_en = 1'b0; wr_lane = 4'h0; ren = 1'b0;
    @(negedge clk);
    pe = 1'b0;
    chk(rdata === 32'h01010101, "R9", "read-first old data", rdata, 32'h01010101);
    read_a(6'd10, 4'h3, 1'b1);
    chk(rdata === 32'h02020202, "R9", "new data afterwards", rdata, 32'h02020202);
  endtask

  task automatic t_rst();
    // rd_rst of the shared-clock instance is held high throughout (R8).
    chk(rvalid === 1'b1, "R8", "unused reset ignored", {31'd0, rvalid}, 32'd1);
    @(negedge clk);
    wrst = 1'b1;
    @(negedge clk);
    wrst = 1'b0;
    chk(rvalid === 1'b0, "R10", "valid cleared by reset", {31'd0, rvalid}, 32'd0);
    chk(rdata === 32'h02020202, "R10", "data kept over reset", rdata, 32'h02020202);
    read_a(6'd10, 4'h3, 1'b1);
    chk(rdata === 32'h02020202, "R10", "memory kept over reset", rdata, 32'h02020202);
  endtask

  task automatic t_split();
    wr_word(6'd5, 32'h5A5A1234, 4'h0);
    @(negedge rclk);
    pe2 = 1'b1; ren2 = 1'b1; raddr2 = 6'd5;
    @(negedge rclk);
    pe2 = 1'b0; ren2 = 1'b0;
    chk(rdata2 === 32'h5A5A1234, "R2", "unmasked write ignores mask", rdata2, 32'h5A5A1234);
    chk(rvalid2 === 1'b1, "R7", "one-edge latency, no out reg", {31'd0, rvalid2}, 32'd1);
    @(negedge rclk);
    rrst = 1'b1;
    @(negedge rclk);
    rrst = 1'b0;
    chk(rvalid2 === 1'b0, "R8", "read reset clears split valid", {31'd0, rvalid2}, 32'd0);
    rclk_run = 1'b0;
    pe2 = 1'b1; ren2 = 1'b1;
    repeat (4) @(negedge clk);
    chk(rvalid2 === 1'b0, "R3", "no read without rd_clk", {31'd0, rvalid2}, 32'd0);
    rclk_run = 1'b1;
    @(negedge rclk);
    pe2 = 1'b0; ren2 = 1'b0;
    chk(rvalid2 === 1'b1, "R3", "read on rd_clk edge", {31'd0, rvalid2}, 32'd1);
    chk(rdata2 === 32'h5A5A1234, "R3", "split read data", rdata2, 32'h5A5A1234);
  endtask

  initial begin
    #(CLK_P * 100000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    wrst = 1'b0;
    @(negedge rclk);
    rrst = 1'b0;
    @(negedge clk);
    t_reset();
    t_mask();
    t_rden();
    t_latency();
    t_hold();
    t_rfirst();
    t_rst();
    t_split();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule